// File: doc/BRIEF.md
# Register-Register 16-bit Adder Core

This block is a small load/store processor whose only arithmetic is 16-bit addition. It keeps five general-purpose 16-bit registers. Its 128-byte byte-addressable memory holds both the program and the data. Memory is touched only by load and store instructions. The add instruction reads two registers and writes a third. Every instruction is one 16-bit word.

The host fills memory one byte at a time through the preload port while the core is not running. It then pulses `start`. The core fetches from address 0 in steps of two until it meets a halt instruction or an illegal encoding. The host then reads results back through the memory peek port and the register peek port.

Each instruction takes two cycles: one to fetch it and one to execute it. Words are stored little-endian: the low byte sits at the even address and the high byte at the next address up.

Top module: `rr16_core`

## Requirements
- R1: After synchronous reset, `halted` and `fault` are 0, every register reads 0 and every memory byte reads 0.
- R2: While the core is not running, a cycle with `pre_we` high writes `pre_byte` to byte `pre_addr`. `peek_byte` always shows the byte at `peek_addr` combinationally.
- R3: The first instruction is fetched from address 0, and each completed instruction advances the fetch address by 2. The instruction word is little-endian. Its opcode sits in bits [15:13]: 000 load, 001 add, 010 store, 111 halt.
- R4: Load (000) writes a register with the memory word addressed by the instruction. The register index is in bits [12:10] and the address in bits [9:3]. Bit 0 of the address is ignored, so an odd address reads the word at the even address below it.
- R5: Add (001) writes the register named in [12:10] with the sum, modulo 2^16, of the registers named in [9:7] and [6:4].
- R6: Store (010) writes the register named in [12:10] to the word at address [9:3], with bit 0 ignored. The low byte goes to the even address and the high byte to the odd address.
- R7: Halt (111) sets `halted` with `fault` low, and the core stays halted until `start`.
- R8: A register field used by the instruction that holds 5, 6 or 7, or an opcode from 011 to 110, halts the core with `fault` set. No register or memory write takes place.
- R9: `pre_we` is ignored while the core is running.
- R10: `start` given while halted clears `fault` and reruns the program from address 0. Register contents are kept.
- R11: `rf_peek_data` shows register `rf_peek_sel` for selections 0 to 4 and reads 0 for 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin execution from address 0 when idle or halted |
| pre_we | input | 1 | Byte preload write enable |
| pre_addr | input | 7 | Byte preload address |
| pre_byte | input | 8 | Byte preload data |
| peek_addr | input | 7 | Memory read-back byte address |
| peek_byte | output | 8 | Memory read-back byte |
| rf_peek_sel | input | 3 | Register read-back index |
| rf_peek_data | output | 16 | Register read-back value |
| halted | output | 1 | Core stopped after halt or fault |
| fault | output | 1 | Last run ended on an illegal encoding |

## Verification
The first program chains loads, adds and stores. The values it uses separate a plain sum from a sum that wraps past 0xFFFF. Its odd-address load shows that bit 0 of the address is dropped, and the stored bytes show the byte order in memory. Further programs plant a bad register index in the destination of a load and in the second source of an add, and one plants an unused opcode. Each of these must stop the core with no write. A plain halt run after a fault shows that `fault` clears while the registers persist across restarts. A preload issued during a run, aimed at an untouched byte, must leave that byte at zero.

// File: rtl/rr16_pkg.sv
package rr16_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = 3;
  localparam int OP_W   = 3;
  localparam int NREGS  = 5;

  localparam logic [OP_W-1:0] OPC_LOAD  = 3'b000;
  localparam logic [OP_W-1:0] OPC_ADD   = 3'b001;
  localparam logic [OP_W-1:0] OPC_STORE = 3'b010;
  localparam logic [OP_W-1:0] OPC_HALT  = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_HALT  = 2'd3
  } core_state_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [IDX_W-1:0]  rd;     // destination / load-store register
    logic [IDX_W-1:0]  rs1;
    logic [IDX_W-1:0]  rs2;
    logic [ADDR_W-1:0] maddr;
  } instr_t;

  function automatic instr_t split_instr(input logic [DATA_W-1:0] w);
    instr_t d;
    d.op    = w[15:13];
    d.rd    = w[12:10];
    d.rs1   = w[9:7];
    d.rs2   = w[6:4];
    d.maddr = w[9:3];
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic idx_valid(input logic [IDX_W-1:0] idx);
    return 32'(idx) < NREGS;
  endfunction

  function automatic logic [ADDR_W-1:0] even_addr(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/rr16_regfile.sv
module rr16_regfile
  import rr16_pkg::*;
#(
  parameter int N_ENT = NREGS,
  parameter int W     = DATA_W,
  parameter int IW    = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b,
  input  logic [IW-1:0] peek_sel,
  output logic [W-1:0]  peek_data
);
  logic [W-1:0] ent_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                              ent_q[g] <= '0;
      else if (we && 32'(waddr) == g)       ent_q[g] <= wdata;
    end
  end

  function automatic logic [W-1:0] pick(input logic [IW-1:0] sel);
    logic [W-1:0] v;
    v = '0;
    for (int i = 0; i < N_ENT; i++)
      if (32'(sel) == i) v = ent_q[i];
    return v;
  endfunction

  assign rdata_a   = pick(raddr_a);
  assign rdata_b   = pick(raddr_b);
  assign peek_data = pick(peek_sel);

  // R8
  wr_idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (32'(waddr) < N_ENT));

  // R5
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (pick($past(waddr)) == $past(wdata)));
endmodule

// File: rtl/rr16_mem.sv
module rr16_mem
  import rr16_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int W     = DATA_W,
  localparam int NBYTES = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_byte,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic [AW-1:0] fetch_addr,
  output logic [W-1:0]  fetch_word,
  input  logic [AW-1:0] ld_addr,
  output logic [W-1:0]  ld_word,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_byte
);
  logic [7:0] byte_q [NBYTES];

  logic [AW-1:0] wr_lo, wr_hi;
  assign wr_lo = even_addr(wr_addr);
  assign wr_hi = even_addr(wr_addr) | AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) byte_q[i] <= '0;
    end else if (wr_en) begin
      byte_q[wr_lo] <= wr_word[7:0];
      byte_q[wr_hi] <= wr_word[15:8];
    end else if (pre_we) begin
      byte_q[pre_addr] <= pre_byte;
    end
  end

  function automatic logic [W-1:0] word_at(input logic [AW-1:0] a);
    logic [AW-1:0] lo;
    lo = even_addr(a);
    return {byte_q[lo | AW'(1)], byte_q[lo]};
  endfunction

  assign fetch_word = word_at(fetch_addr);
  assign ld_word    = word_at(ld_addr);
  assign peek_byte  = byte_q[peek_addr];

  // R9
  ports_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && pre_we));

  // R6
  store_order_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (word_at($past(wr_addr)) == $past(wr_word)));
endmodule

// File: rtl/rr16_seq.sv
module rr16_seq
  import rr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] fetch_pc,
  input  logic [DATA_W-1:0] fetch_word,
  output logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_word,
  output logic [IDX_W-1:0]  rf_raddr_a,
  input  logic [DATA_W-1:0] rf_rdata_a,
  output logic [IDX_W-1:0]  rf_raddr_b,
  input  logic [DATA_W-1:0] rf_rdata_b,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              running,
  output logic              halted,
  output logic              fault
);
  core_state_e       state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic              fault_q;
  instr_t            dec;
  logic              legal;
  logic              in_exec;
  logic              illegal_evt;
  logic              halt_evt;
  logic              unused_ir_bits;

  assign dec            = split_instr(ir_q);
  assign unused_ir_bits = ^ir_q[2:0];
  assign in_exec        = (state_q == ST_EXEC);

  always_comb begin
    unique case (dec.op)
      OPC_LOAD, OPC_STORE: legal = idx_valid(dec.rd);
      OPC_ADD:             legal = idx_valid(dec.rd) && idx_valid(dec.rs1) && idx_valid(dec.rs2);
      OPC_HALT:            legal = 1'b1;
      default:             legal = 1'b0;
    endcase
  end

  assign illegal_evt = in_exec && !legal;
  assign halt_evt    = in_exec && legal && (dec.op == OPC_HALT);

  // operand routing
  assign rf_raddr_a = (dec.op == OPC_STORE) ? dec.rd : dec.rs1;
  assign rf_raddr_b = dec.rs2;
  assign ld_addr    = dec.maddr;
  assign fetch_pc   = pc_q;

  always_comb begin
    rf_we     = 1'b0;
    rf_waddr  = dec.rd;
    rf_wdata  = '0;
    mem_we    = 1'b0;
    mem_waddr = dec.maddr;
    mem_wdata = rf_rdata_a;
    if (in_exec && legal) begin
      unique case (dec.op)
        OPC_LOAD: begin
          rf_we    = 1'b1;
          rf_wdata = ld_word;
        end
        OPC_ADD: begin
          rf_we    = 1'b1;
          rf_wdata = wrap_add(rf_rdata_a, rf_rdata_b);
        end
        OPC_STORE: mem_we = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            fault_q <= 1'b0;
          end
        end
        ST_FETCH: begin
          ir_q    <= fetch_word;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (illegal_evt) begin
            state_q <= ST_HALT;
            fault_q <= 1'b1;
          end else if (halt_evt) begin
            state_q <= ST_HALT;
          end else begin
            pc_q    <= pc_q + ADDR_W'(2);
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign running = (state_q == ST_FETCH) || in_exec;
  assign halted  = (state_q == ST_HALT);
  assign fault   = fault_q;

  // R8
  illegal_stops_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_evt |=> (halted && fault));

  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_evt |-> (!rf_we && !mem_we));

  // R7
  halt_clean_chk: assert property (@(posedge clk) disable iff (rst)
    halt_evt |=> (halted && !fault));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> halted);

  // R3
  pc_even_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (pc_q[0] == 1'b0));

  // R10
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && start) |=> (!fault && running && pc_q == '0));
endmodule

// File: rtl/rr16_core.sv
module rr16_core
  import rr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_byte,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_byte,
  input  logic [IDX_W-1:0]  rf_peek_sel,
  output logic [DATA_W-1:0] rf_peek_data,
  output logic              halted,
  output logic              fault
);
  logic [ADDR_W-1:0] fetch_pc, ld_addr, mem_waddr;
  logic [DATA_W-1:0] fetch_word, ld_word, mem_wdata;
  logic [IDX_W-1:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [DATA_W-1:0] rf_rdata_a, rf_rdata_b, rf_wdata;
  logic              rf_we, mem_we, running;
  logic              pre_we_gated;

  assign pre_we_gated = pre_we && !running;

  rr16_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .fetch_pc   (fetch_pc),
    .fetch_word (fetch_word),
    .ld_addr    (ld_addr),
    .ld_word    (ld_word),
    .rf_raddr_a (rf_raddr_a),
    .rf_rdata_a (rf_rdata_a),
    .rf_raddr_b (rf_raddr_b),
    .rf_rdata_b (rf_rdata_b),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .running    (running),
    .halted     (halted),
    .fault      (fault)
  );

  rr16_regfile u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata),
    .raddr_a   (rf_raddr_a),
    .rdata_a   (rf_rdata_a),
    .raddr_b   (rf_raddr_b),
    .rdata_b   (rf_rdata_b),
    .peek_sel  (rf_peek_sel),
    .peek_data (rf_peek_data)
  );

  rr16_mem u_mem (
    .clk        (clk),
    .rst        (rst),
    .pre_we     (pre_we_gated),
    .pre_addr   (pre_addr),
    .pre_byte   (pre_byte),
    .wr_en      (mem_we),
    .wr_addr    (mem_waddr),
    .wr_word    (mem_wdata),
    .fetch_addr (fetch_pc),
    .fetch_word (fetch_word),
    .ld_addr    (ld_addr),
    .ld_word    (ld_word),
    .peek_addr  (peek_addr),
    .peek_byte  (peek_byte)
  );

  // R9
  preload_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_we && running) |-> !pre_we_gated);

  // R8
  stop_without_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!rf_we && !mem_we));
endmodule

// File: tb/rr16_core_tb.sv
`timescale 1ns/1ps
module rr16_core_tb_top;
  logic        clk = 1'b0;
  logic        rst, start, pre_we;
  logic [6:0]  pre_addr, peek_addr;
  logic [7:0]  pre_byte, peek_byte;
  logic [2:0]  rf_peek_sel;
  logic [15:0] rf_peek_data;
  logic        halted, fault;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rr16_core dut_i (
    .clk(clk), .rst(rst), .start(start),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_byte(pre_byte),
    .peek_addr(peek_addr), .peek_byte(peek_byte),
    .rf_peek_sel(rf_peek_sel), .rf_peek_data(rf_peek_data),
    .halted(halted), .fault(fault)
  );

  // scoreboard: 0 = register, 1 = memory byte, 2 = halted, 3 = fault
  int    q_kind[$];
  int    q_idx[$];
  int    q_val[$];
  string q_req[$];
  event  drain_ev, drain_done;

  function automatic logic [15:0] mk_ld(int r, int a);
    return {3'b000, 3'(r), 7'(a), 3'b000};
  endfunction
  function automatic logic [15:0] mk_st(int r, int a);
    return {3'b010, 3'(r), 7'(a), 3'b000};
  endfunction
  function automatic logic [15:0] mk_add(int d, int s1, int s2);
    return {3'b001, 3'(d), 3'(s1), 3'(s2), 4'b0000};
  endfunction
  function automatic int sum16(int a, int b);
    return (a + b) % 65536;
  endfunction

  task automatic expect_item(int kind, int idx, int val, string req);
    q_kind.push_back(kind); q_idx.push_back(idx);
    q_val.push_back(val);   q_req.push_back(req);
  endtask

  task automatic drain();
    -> drain_ev;
    @(drain_done);
  endtask

  // monitor: owns the peek inputs, pops and compares expected items
  initial begin
    rf_peek_sel = '0;
    peek_addr   = '0;
    forever begin
      @(drain_ev);
      while (q_kind.size() > 0) begin
        int k, ix, ev, act;
        string rq;
        k = q_kind.pop_front(); ix = q_idx.pop_front();
        ev = q_val.pop_front(); rq = q_req.pop_front();
        case (k)
          0: begin rf_peek_sel = 3'(ix); #1; act = int'(rf_peek_data); end
          1: begin peek_addr = 7'(ix);   #1; act = int'(peek_byte);    end
          2: begin #1; act = int'(halted); end
          default: begin #1; act = int'(fault); end
        endcase
        n_tests++;
        if (act != ev) begin
          n_fail++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", rq, k, ix, act, ev);
        end
      end
      -> drain_done;
    end
  end

  task automatic poke(int a, int b);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = 7'(a); pre_byte = 8'(b);
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic poke_word(int a, logic [15:0] w);
    poke(a, int'(w[7:0]));
    poke(a + 1, int'(w[15:8]));
  endtask

  task automatic run_prog(bit inject);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (inject) begin
      pre_we = 1'b1; pre_addr = 7'd100; pre_byte = 8'hAA;
      @(negedge clk); pre_we = 1'b0;
    end
    n = 0;
    while (!halted && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) begin
      n_tests++; n_fail++;
      $display("FAIL R7 watchdog: halted actual=0 expected=1");
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; pre_we = 1'b0; pre_addr = '0; pre_byte = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    expect_item(2, 0, 0, "R1");
    expect_item(3, 0, 0, "R1");
    for (int r = 0; r < 5; r++) expect_item(0, r, 0, "R1");
    expect_item(1, 0, 0, "R1");
    expect_item(1, 127, 0, "R1");
    drain();

    // program 1: loads, plain and wrapping add, stores, odd-address load
    poke_word(64, 16'h1234);
    poke_word(66, 16'hFFFF);
    poke_word(68, 16'h0001);
    poke_word(0,  mk_ld(1, 64));
    poke_word(2,  mk_ld(2, 66));
    poke_word(4,  mk_ld(3, 68));
    poke_word(6,  mk_add(0, 1, 2));
    poke_word(8,  mk_add(4, 2, 3));
    poke_word(10, mk_st(0, 70));
    poke_word(12, mk_st(4, 72));
    poke_word(14, mk_ld(2, 71));
    poke_word(16, 16'hE000);
    expect_item(1, 65, 8'h12, "R2");
    drain();
    run_prog(1'b1);
    expect_item(2, 0, 1, "R7");
    expect_item(3, 0, 0, "R7");
    expect_item(0, 1, 16'h1234, "R4");
    expect_item(0, 3, 16'h0001, "R4");
    expect_item(0, 0, sum16(16'h1234, 16'hFFFF), "R5");
    expect_item(0, 4, sum16(16'hFFFF, 1), "R5");
    expect_item(1, 70, 8'h33, "R6");
    expect_item(1, 71, 8'h12, "R6");
    expect_item(1, 72, 8'h00, "R6");
    expect_item(0, 2, sum16(16'h1234, 16'hFFFF), "R4");
    expect_item(1, 100, 0, "R9");
    expect_item(0, 5, 0, "R11");
    expect_item(0, 7, 0, "R11");
    drain();

    // program 2: double r1, then load into r5 (bad destination)
    poke_word(0, mk_add(1, 1, 1));
    poke_word(2, mk_ld(5, 64));
    poke_word(4, mk_st(1, 80));
    poke_word(6, 16'hE000);
    run_prog(1'b0);
    expect_item(2, 0, 1, "R8");
    expect_item(3, 0, 1, "R8");
    expect_item(0, 1, 16'h2468, "R10");
    expect_item(0, 5, 0, "R8");
    expect_item(1, 80, 0, "R8");
    expect_item(1, 81, 0, "R8");
    drain();

    // program 3: unused opcode 011
    poke_word(0, 16'h6000);
    run_prog(1'b0);
    expect_item(3, 0, 1, "R8");
    expect_item(0, 1, 16'h2468, "R8");
    drain();

    // program 4: plain halt after a fault clears fault
    poke_word(0, 16'hE000);
    run_prog(1'b0);
    expect_item(2, 0, 1, "R10");
    expect_item(3, 0, 0, "R10");
    drain();

    // program 5: add with second source 7
    poke_word(0, mk_add(0, 1, 7));
    run_prog(1'b0);
    expect_item(3, 0, 1, "R8");
    expect_item(0, 0, sum16(16'h1234, 16'hFFFF), "R8");
    drain();

    // program 6: fetch order from address 0 in steps of two
    poke_word(0, mk_add(3, 3, 3));
    poke_word(2, mk_add(3, 3, 3));
    poke_word(4, 16'hE000);
    poke_word(6, mk_add(3, 3, 3));
    run_prog(1'b0);
    expect_item(0, 3, 4, "R3");
    expect_item(3, 0, 0, "R3");
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_tests++; n_fail++;
    $display("FAIL R7 global watchdog: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule